// File: doc/BRIEF.md
# Clock Synthesizer Mode and Power-Down Sequencer

This block is the digital controller of a multi-output clock synthesizer with four output groups: the CPU pairs, the PCI clock, the 48 MHz clock and the reference clock. A three-bit strap sets the mode. It has one speed-select pin and a two-bit frequency-select field. The block turns the strap into a run, stopped-low or high-impedance mode for each group, and into a frequency code for the CPU synthesizer. It gates each group's output clock so that the output only ever starts and stops from a low level.

The block runs on the reference-oscillator clock. In test mode that pin carries an external test clock, and each group's output is that clock divided down. An active-low power-down request arrives asynchronously. It passes through a two-flop synchronizer and then stops every output low. After that the VCO enable is removed, then the crystal enable. Releasing the request replays the sequence in reverse, and a PLL lock handshake paces the restart. An active-low spread request is synchronized and handed to the CPU synthesizer only. A strap change while running parks all outputs low for at least one full period of the slowest output before the new mode takes effect.

Top module: `clkgen_ctrl`

## Requirements
- R1: With `speed_sel`=0, `fsel`=0 runs all groups with `cpu_freq`=0 (100 MHz code). `fsel`=1 holds the 48 MHz group (index 2) low. `fsel`=2 holds the PCI (index 1) and 48 MHz groups low. In normal mode a running group's output period is 2×its half-period parameter in clock cycles.
- R2: With `speed_sel`=0 and `fsel`=3, every bit of `grp_oe` is 0, while `xtal_en` and `vco_en` keep their values.
- R3: With `speed_sel`=1, `fsel`=0 gives `cpu_freq`=1 (133 MHz code) with all groups running. `fsel`=1 gives `cpu_freq`=1 with the 48 MHz group held low. `fsel`=2 gives `cpu_freq`=2 (200 MHz code) with all groups running.
- R4: With `speed_sel`=1 and `fsel`=3 (test mode, `cpu_freq`=3), the CPU group (index 0) and the 48 MHz group have a period of 2 clock cycles. The PCI group has a period of 8. The reference group (index 3) keeps its normal period.
- R5: `pd_n` acts only after two synchronizing flops. Each running output then finishes its current high phase, falls, and is held low.
- R6: `vco_en` falls only when all four group clocks are low. `xtal_en` falls one cycle after `vco_en` has fallen.
- R7: After reset or power-down release, `xtal_en` rises first. `vco_en` rises SETTLE cycles later. Outputs are released once `pll_lock` is seen or LOCK_TO cycles have passed, and each output's first edge is a rising edge one half-period after release.
- R8: A strap change while running keeps all group clocks low for at least twice the largest half-period before the new mode is applied.
- R9: Power-down is carried out in high-impedance mode and in test mode.
- R10: `cpu_spread` equals the inverse of `spread_n` delayed by two flops. The other groups' periods are unchanged while it is set.
- R11: During reset, `xtal_en`=1, `vco_en`=0, all group clocks are 0, and the strap-0 mode is applied (all `grp_oe` bits 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock (test clock in test mode) |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| spread_n | input | 1 | Spread-spectrum request, active low |
| speed_sel | input | 1 | Strap: speed select |
| fsel | input | 2 | Strap: frequency select code |
| pll_lock | input | 1 | Lock indication from the CPU PLL |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| cpu_freq | output | 2 | CPU frequency code: 0=100, 1=133, 2=200, 3=test |
| cpu_spread | output | 1 | Down-spread enable to the CPU synthesizer |
| grp_clk | output | 4 | Gated group clocks: 0 CPU, 1 PCI, 2 48 MHz, 3 reference |
| grp_oe | output | 4 | Per-group output drive enable |

## Verification
The bench builds the block with SETTLE=6, LOCK_TO=10 and half-periods of 2, 5, 3 and 4 cycles. With these values every group has a different period, so a swapped divisor or a wrong test-mode ratio shows up as a wrong measured period. The park window (10 cycles) is short enough that its minimum length can be measured directly. The lock timeout path is exercised after reset and the lock handshake path on recovery, so both release conditions of the sequencer are checked with exact cycle counts.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int NGRP  = 4;
    localparam int G_CPU = 0;
    localparam int G_PCI = 1;
    localparam int G_USB = 2;
    localparam int G_REF = 3;

    // Test-mode half periods, in clock cycles
    localparam int TST_HALF_FAST = 1;
    localparam int TST_HALF_PCI  = 4;

    typedef enum logic [1:0] {GM_RUN = 2'd0, GM_STOP = 2'd1, GM_HIZ = 2'd2} gmode_e;
    typedef enum logic [1:0] {CF_100 = 2'd0, CF_133 = 2'd1, CF_200 = 2'd2, CF_TEST = 2'd3} cfreq_e;

    typedef struct packed {
        logic [NGRP-1:0][1:0] grp;
        cfreq_e               freq;
        logic                 test;
    } mode_t;

    typedef enum logic [2:0] {
        S_XTAL, S_LOCK, S_RUN, S_PARK, S_STOP, S_VCOOFF, S_DOWN
    } seq_e;

    function automatic mode_t decode_strap(input logic spd, input logic [1:0] fs);
        mode_t m;
        for (int g = 0; g < NGRP; g++) m.grp[g] = GM_RUN;
        m.freq = CF_100;
        m.test = 1'b0;
        case ({spd, fs})
            3'b001: m.grp[G_USB] = GM_STOP;
            3'b010: begin
                m.grp[G_PCI] = GM_STOP;
                m.grp[G_USB] = GM_STOP;
            end
            3'b011: for (int g = 0; g < NGRP; g++) m.grp[g] = GM_HIZ;
            3'b100: m.freq = CF_133;
            3'b101: begin
                m.freq = CF_133;
                m.grp[G_USB] = GM_STOP;
            end
            3'b110: m.freq = CF_200;
            3'b111: begin
                m.freq = CF_TEST;
                m.test = 1'b1;
            end
            default: ;
        endcase
        return m;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkgen_outdiv.sv
module clkgen_outdiv #(
    parameter int HW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          clk_o
);
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            clk_o <= 1'b0;
        end else if (!run && !clk_o) begin
            cnt <= '0;
        end else if (cnt == half - 1'b1) begin
            cnt   <= '0;
            clk_o <= ~clk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clk_o) |=> !clk_o);

    // R7
    start_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_o) |-> $past(run));
endmodule

// File: rtl/clkgen_seq.sv
module clkgen_seq
    import clkgen_pkg::*;
#(
    parameter int SETTLE  = 6,
    parameter int LOCK_TO = 10,
    parameter int PARK    = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic lock,
    input  logic all_low,
    input  logic mode_diff,
    output logic xtal_en,
    output logic vco_en,
    output logic running,
    output logic load
);
    localparam int MAXC = imax(imax(SETTLE, LOCK_TO), PARK);
    localparam int CW   = $clog2(MAXC + 1);

    seq_e          st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_XTAL;
            cnt <= '0;
        end else begin
            case (st)
                S_XTAL: begin
                    if (pd_req) st <= S_VCOOFF;
                    else if (cnt == CW'(SETTLE - 1)) begin
                        st  <= S_LOCK;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_LOCK: begin
                    if (pd_req) st <= S_VCOOFF;
                    else if (lock || cnt == CW'(LOCK_TO - 1)) begin
                        st  <= S_RUN;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_RUN: begin
                    cnt <= '0;
                    if (pd_req) st <= S_STOP;
                    else if (mode_diff) st <= S_PARK;
                end
                S_PARK: begin
                    if (pd_req) st <= S_STOP;
                    else if (!all_low) cnt <= '0;
                    else if (cnt == CW'(PARK - 1)) begin
                        st  <= S_RUN;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                S_STOP:   if (all_low) st <= S_VCOOFF;
                S_VCOOFF: st <= S_DOWN;
                S_DOWN: begin
                    cnt <= '0;
                    if (!pd_req) st <= S_XTAL;
                end
                default: st <= S_XTAL;
            endcase
        end
    end

    always_comb begin
        xtal_en = (st != S_DOWN);
        vco_en  = (st == S_LOCK) || (st == S_RUN) || (st == S_PARK) || (st == S_STOP);
        running = (st == S_RUN);
        load    = (st == S_XTAL) || (st == S_LOCK) || (st == S_DOWN) ||
                  (st == S_PARK && !pd_req && all_low && cnt == CW'(PARK - 1));
    end

    // R6
    vco_off_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vco_en) |-> all_low);

    // R6
    xtal_after_vco_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xtal_en) |-> $past(!vco_en));

    // R7
    vco_after_xtal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vco_en) |-> $past(xtal_en));
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter int SETTLE   = 6,
    parameter int LOCK_TO  = 10,
    parameter int CPU_HALF = 2,
    parameter int PCI_HALF = 5,
    parameter int USB_HALF = 3,
    parameter int REF_HALF = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_n,
    input  logic       spread_n,
    input  logic       speed_sel,
    input  logic [1:0] fsel,
    input  logic       pll_lock,
    output logic       xtal_en,
    output logic       vco_en,
    output logic [1:0] cpu_freq,
    output logic       cpu_spread,
    output logic [3:0] grp_clk,
    output logic [3:0] grp_oe
);
    localparam int MAXH = imax(imax(imax(CPU_HALF, PCI_HALF), imax(USB_HALF, REF_HALF)), TST_HALF_PCI);
    localparam int HW   = $clog2(MAXH + 1);
    localparam int PARK = 2 * MAXH;

    logic [2:0] strap_s;
    logic       pd_s, ss_s;
    logic       running, load, all_low;
    mode_t      mode_q, mode_new;

    clkgen_sync #(.W(3), .INIT(3'b000)) u_strap_sync (
        .clk(clk), .rst(rst), .d({speed_sel, fsel}), .q(strap_s));
    clkgen_sync #(.W(1), .INIT(1'b1)) u_pd_sync (
        .clk(clk), .rst(rst), .d(pd_n), .q(pd_s));
    clkgen_sync #(.W(1), .INIT(1'b1)) u_ss_sync (
        .clk(clk), .rst(rst), .d(spread_n), .q(ss_s));

    assign mode_new = decode_strap(strap_s[2], strap_s[1:0]);
    assign all_low  = ~|grp_clk;

    clkgen_seq #(.SETTLE(SETTLE), .LOCK_TO(LOCK_TO), .PARK(PARK)) u_seq (
        .clk(clk), .rst(rst), .pd_req(~pd_s), .lock(pll_lock),
        .all_low(all_low), .mode_diff(mode_new != mode_q),
        .xtal_en(xtal_en), .vco_en(vco_en), .running(running), .load(load));

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= decode_strap(1'b0, 2'b00);
        else if (load) mode_q <= mode_new;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int NH = (g == G_CPU) ? CPU_HALF :
                            (g == G_PCI) ? PCI_HALF :
                            (g == G_USB) ? USB_HALF : REF_HALF;
        localparam int TH = (g == G_PCI) ? TST_HALF_PCI :
                            (g == G_REF) ? REF_HALF : TST_HALF_FAST;
        logic [HW-1:0] half;
        logic          gate;

        assign half      = mode_q.test ? HW'(TH) : HW'(NH);
        assign gate      = running && (mode_q.grp[g] == GM_RUN);
        assign grp_oe[g] = (mode_q.grp[g] != GM_HIZ);

        clkgen_outdiv #(.HW(HW)) u_div (
            .clk(clk), .rst(rst), .run(gate), .half(half), .clk_o(grp_clk[g]));
    end

    assign cpu_freq   = mode_q.freq;
    assign cpu_spread = ~ss_s;

    // R8
    mode_switch_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> $past(all_low));

    // R2
    hiz_pll_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_oe == 4'b0000 && $past(grp_oe == 4'b0000) && running) |-> vco_en && xtal_en);
endmodule

// File: tb/clkgen_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_ctrl_test;
    localparam int SETTLE = 6, LOCK_TO = 10;
    localparam int CH = 2, PH = 5, UH = 3, RH = 4;
    localparam int PARK = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic pd_n = 1'b1, spread_n = 1'b1, speed_sel = 1'b0, pll_lock = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic xtal_en, vco_en, cpu_spread;
    logic [1:0] cpu_freq;
    logic [3:0] grp_clk, grp_oe;

    int checks = 0, failures = 0, cyc = 0;
    int vco_fall_cyc = -1;
    logic prev_vco = 1'b0, prev_xtal = 1'b1;

    always #2.5 clk = ~clk;

    clkgen_ctrl #(.SETTLE(SETTLE), .LOCK_TO(LOCK_TO), .CPU_HALF(CH),
                  .PCI_HALF(PH), .USB_HALF(UH), .REF_HALF(RH)) uut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .spread_n(spread_n),
        .speed_sel(speed_sel), .fsel(fsel), .pll_lock(pll_lock),
        .xtal_en(xtal_en), .vco_en(vco_en), .cpu_freq(cpu_freq),
        .cpu_spread(cpu_spread), .grp_clk(grp_clk), .grp_oe(grp_oe));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle order monitor (R6)
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_vco && !vco_en) begin
                vco_fall_cyc = cyc;
                chk(grp_clk == 4'b0, "R6 clocks low at vco off", int'(grp_clk), 0);
            end
            if (prev_xtal && !xtal_en)
                chk(!vco_en && vco_fall_cyc > 0 && cyc - vco_fall_cyc == 1,
                    "R6 xtal off one cycle after vco off", cyc - vco_fall_cyc, 1);
        end
        prev_vco  = vco_en;
        prev_xtal = xtal_en;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic measure(input int g, output int p);
        int k = 0;
        p = -1;
        while (grp_clk[g] !== 1'b0 && k < 100) begin @(negedge clk); k++; end
        while (grp_clk[g] !== 1'b1 && k < 200) begin @(negedge clk); k++; end
        if (k >= 200) return;
        k = 0;
        do begin @(negedge clk); k++; end while (grp_clk[g] !== 1'b0 && k < 100);
        while (grp_clk[g] !== 1'b1 && k < 200) begin @(negedge clk); k++; end
        if (k < 200) p = k;
    endtask

    task automatic ever_high(input int g, input int n, output bit h);
        h = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (grp_clk[g]) h = 1'b1;
        end
    endtask

    // Apply a strap and return the longest all-low run seen while it settles
    task automatic set_strap(input logic s, input logic [1:0] f, output int lowrun);
        int run = 0;
        lowrun = 0;
        speed_sel = s;
        fsel = f;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (grp_clk == 4'b0) run++; else run = 0;
            if (run > lowrun) lowrun = run;
        end
    endtask

    task automatic wait_down(output int k);
        k = 0;
        while (xtal_en && k < 200) begin @(negedge clk); k++; end
    endtask

    initial begin
        int k, p, lr;
        bit h;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(xtal_en && !vco_en, "R11 enables in reset", {xtal_en, vco_en}, 2);
        chk(grp_clk == 4'b0 && grp_oe == 4'hF, "R11 outputs in reset", {grp_clk, grp_oe}, 15);
        rst = 1'b0;
        // R7 xtal to vco settle count, lock timeout path
        k = 0;
        while (!vco_en && k < 100) begin @(negedge clk); k++; end
        chk(k == SETTLE, "R7 settle cycles", k, SETTLE);
        k = 0;
        while (!grp_clk[0] && k < 100) begin @(negedge clk); k++; end
        chk(k == LOCK_TO + CH, "R7 release on timeout", k, LOCK_TO + CH);

        // R1 all running, normal periods
        measure(0, p); chk(p == 2*CH, "R1 cpu period", p, 2*CH);
        measure(1, p); chk(p == 2*PH, "R1 pci period", p, 2*PH);
        measure(2, p); chk(p == 2*UH, "R1 usb period", p, 2*UH);
        measure(3, p); chk(p == 2*RH, "R1 ref period", p, 2*RH);
        chk(cpu_freq == 2'd0, "R1 freq code", cpu_freq, 0);

        set_strap(1'b0, 2'd1, lr);
        chk(lr >= PARK, "R8 park window", lr, PARK);
        ever_high(2, 40, h); chk(!h && grp_oe[2], "R1 usb stopped low", h, 0);
        measure(1, p); chk(p == 2*PH, "R1 pci runs fsel1", p, 2*PH);

        set_strap(1'b0, 2'd2, lr);
        chk(lr >= PARK, "R8 park window 2", lr, PARK);
        ever_high(1, 40, h); chk(!h, "R1 pci stopped fsel2", h, 0);
        ever_high(2, 20, h); chk(!h, "R1 usb stopped fsel2", h, 0);
        measure(0, p); chk(p == 2*CH, "R1 cpu runs fsel2", p, 2*CH);

        set_strap(1'b0, 2'd3, lr);
        chk(grp_oe == 4'b0, "R2 all oe low", grp_oe, 0);
        chk(vco_en && xtal_en, "R2 pll enables kept", {xtal_en, vco_en}, 3);

        set_strap(1'b1, 2'd0, lr);
        chk(cpu_freq == 2'd1, "R3 133 code", cpu_freq, 1);
        measure(2, p); chk(p == 2*UH, "R3 usb runs", p, 2*UH);
        set_strap(1'b1, 2'd1, lr);
        chk(cpu_freq == 2'd1, "R3 133 code fsel1", cpu_freq, 1);
        ever_high(2, 40, h); chk(!h, "R3 usb stopped", h, 0);
        set_strap(1'b1, 2'd2, lr);
        chk(cpu_freq == 2'd2, "R3 200 code", cpu_freq, 2);
        measure(1, p); chk(p == 2*PH, "R3 pci runs", p, 2*PH);

        set_strap(1'b1, 2'd3, lr);
        chk(cpu_freq == 2'd3, "R4 test code", cpu_freq, 3);
        measure(0, p); chk(p == 2, "R4 cpu test period", p, 2);
        measure(1, p); chk(p == 8, "R4 pci test period", p, 8);
        measure(2, p); chk(p == 2, "R4 usb test period", p, 2);
        measure(3, p); chk(p == 2*RH, "R4 ref test period", p, 2*RH);

        // R5 sync latency and R9 power-down in test mode
        pd_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(vco_en, "R5 no action before sync", vco_en, 1);
        wait_down(k);
        chk(!xtal_en && !vco_en, "R9 test mode power-down", {xtal_en, vco_en}, 0);
        ever_high(0, 20, h);
        chk(!h && grp_clk == 4'b0 && !xtal_en, "R5 outputs held low", grp_clk, 0);

        // R7 recovery with lock handshake
        pd_n = 1'b1;
        k = 0;
        while (!xtal_en && k < 100) begin @(negedge clk); k++; end
        chk(k == 3, "R7 xtal after release", k, 3);
        k = 0;
        while (!vco_en && k < 100) begin @(negedge clk); k++; end
        chk(k == SETTLE, "R7 settle on recovery", k, SETTLE);
        pll_lock = 1'b1;
        k = 0;
        while (!grp_clk[0] && k < 100) begin @(negedge clk); k++; end
        chk(k == 2, "R7 release on lock", k, 2);

        // R9 power-down in high-impedance mode
        set_strap(1'b0, 2'd3, lr);
        pd_n = 1'b0;
        wait_down(k);
        chk(!xtal_en && !vco_en && k < 200, "R9 hiz power-down", {xtal_en, vco_en}, 0);
        pd_n = 1'b1;
        repeat (30) @(negedge clk);

        // R10 spread sync and isolation
        set_strap(1'b0, 2'd0, lr);
        spread_n = 1'b0;
        @(negedge clk);
        chk(!cpu_spread, "R10 spread after one flop", cpu_spread, 0);
        @(negedge clk);
        chk(cpu_spread, "R10 spread after two flops", cpu_spread, 1);
        measure(1, p); chk(p == 2*PH, "R10 pci unaffected", p, 2*PH);
        measure(2, p); chk(p == 2*UH, "R10 usb unaffected", p, 2*UH);
        spread_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cpu_spread, "R10 spread released", cpu_spread, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule